// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words on one data line while producing the shift clock itself. A programmable divider sets the clock rate. The host starts a transfer in one of two ways. A one-shot request captures a single word and then drops by itself. A continuous request keeps capturing words until the host withdraws it. Words are 8 bits long, or 9 bits when the ninth-bit option is on, and arrive least significant bit first.

Each finished word moves into a two-entry queue. A ready flag and a maskable interrupt tell the host that data is waiting. The host pulls words out with a read strobe, which loads the data byte and its ninth bit into visible output registers. If a word completes while the queue is full, an overrun flag is raised. That flag stays set and blocks all further queue writes until the host clears the continuous request.

Top module: `sync_rx_master`

## Requirements
- R1: A control write (`ctl_wr`) loads four bits from `ctl_wdata`: bit 0 one-shot request, bit 1 continuous request, bit 2 ninth-bit mode, bit 3 interrupt enable. While both requests are clear the receiver is idle and `sclk_o` stays low.
- R2: While receiving, `sclk_o` has a period of 2×(divider+1) system clocks, where the divider is set through `div_wr`/`div_wdata`. The first rising edge comes divider+1 clocks after the request is registered.
- R3: `sdata_i` is sampled on each falling edge of `sclk_o`, least significant bit first. A word has 8 bits, or 9 in ninth-bit mode, and the ninth bit is reported on `rx_bit9` (0 in 8-bit mode).
- R4: In one-shot mode with the continuous request clear, exactly one word is captured. `single_on` then clears by itself and `sclk_o` stays low.
- R5: When both requests are set, reception is continuous and `single_on` remains set after each word.
- R6: The queue holds two words and returns them in arrival order. A `data_rd` pulse on a non-empty queue loads `rx_data` and `rx_bit9` from the head in the next cycle.
- R7: `rx_ready` is high whenever the queue holds a word and clears once reads have emptied it. `irq` equals `rx_ready` gated by the interrupt enable.
- R8: A word that completes while the queue is full is discarded and sets `overrun`. While `overrun` is set, no completed word enters the queue.
- R9: `overrun` stays set until a control write with the continuous request bit clear. A control write that keeps that bit set leaves `overrun` unchanged.
- R10: A `data_rd` pulse on an empty queue leaves `rx_data`, `rx_bit9`, `rx_ready` and `overrun` unchanged.
- R11: Reset clears all registers, so every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control bits: one-shot, continuous, ninth bit, interrupt enable |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W (8) | Divider value |
| data_rd | input | 1 | Read strobe, pops one queue entry |
| sdata_i | input | 1 | Serial data line |
| sclk_o | output | 1 | Generated shift clock |
| rx_data | output | DATA_W (8) | Last popped data byte |
| rx_bit9 | output | 1 | Ninth bit of the last popped word |
| rx_ready | output | 1 | Queue holds at least one word |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |
| single_on | output | 1 | One-shot request still pending |

## Verification
The bench uses random 8-bit and 9-bit words at random divider settings in one-shot mode. A bit-order or sampling-edge fault shows up as a scrambled value, and a divider fault shows up in the measured edge spacing. Continuous streams of two words check queue order and the precedence of the continuous request over the one-shot request. A stream of five words with no reads fills the queue and separates the first two stored words from the discarded ones. It also shows whether overrun really blocks later transfers and whether only clearing the continuous request releases it. Reads on an empty queue must leave the held values untouched.

// File: rtl/srx_pkg.sv
package srx_pkg;
    // control word bit positions
    localparam int CTL_W      = 4;
    localparam int CTL_SINGLE = 0;
    localparam int CTL_CONT   = 1;
    localparam int CTL_NINE   = 2;
    localparam int CTL_IRQEN  = 3;
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        fall_tick = 1'b0;
        if (!run) begin
            nxt_d.cnt  = '0;
            nxt_d.sclk = 1'b0;
        end else if (cur_q.cnt == div) begin
            nxt_d.cnt  = '0;
            nxt_d.sclk = ~cur_q.sclk;
            fall_tick  = cur_q.sclk;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign sclk = cur_q.sclk;
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
    parameter int DATA_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          fall_tick,
    input  logic          sdata,
    input  logic          nine,
    output logic          done,
    output logic [DATA_W:0] word
);
    localparam int WORD_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] bits;
        logic [CNT_W-1:0]  idx;
    } st_t;

    st_t cur_q, nxt_d;
    logic [CNT_W-1:0]  last_idx;
    logic [WORD_W-1:0] assembled;

    always_comb begin
        last_idx  = nine ? CNT_W'(WORD_W - 1) : CNT_W'(DATA_W - 1);
        assembled = cur_q.bits;
        assembled[cur_q.idx] = sdata;
        nxt_d = cur_q;
        done  = 1'b0;
        if (!run) begin
            nxt_d = '0;
        end else if (fall_tick) begin
            if (cur_q.idx == last_idx) begin
                done       = 1'b1;
                nxt_d.bits = '0;
                nxt_d.idx  = '0;
            end else begin
                nxt_d.bits = assembled;
                nxt_d.idx  = cur_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign word = assembled;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            count;
    } st_t;

    st_t  cur_q, nxt_d;
    logic do_pop, do_push;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (cur_q.count == '0);
        full    = (cur_q.count == CNT_W'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        nxt_d   = cur_q;
        if (do_push) begin
            nxt_d.mem[cur_q.wr] = push_data;
            nxt_d.wr            = step(cur_q.wr);
        end
        if (do_pop) nxt_d.rd = step(cur_q.rd);
        case ({do_push, do_pop})
            2'b10:   nxt_d.count = cur_q.count + 1'b1;
            2'b01:   nxt_d.count = cur_q.count - 1'b1;
            default: nxt_d.count = cur_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign head = cur_q.mem[cur_q.rd];
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_wr,
    input  logic [srx_pkg::CTL_W-1:0] ctl_wdata,
    input  logic                     div_wr,
    input  logic [DIV_W-1:0]         div_wdata,
    input  logic                     data_rd,
    input  logic                     sdata_i,
    output logic                     sclk_o,
    output logic [DATA_W-1:0]        rx_data,
    output logic                     rx_bit9,
    output logic                     rx_ready,
    output logic                     overrun,
    output logic                     irq,
    output logic                     single_on
);
    import srx_pkg::*;

    localparam int WORD_W = DATA_W + 1;

    typedef struct packed {
        logic              single;
        logic              cont;
        logic              nine;
        logic              irq_en;
        logic [DIV_W-1:0]  div;
        logic              overrun;
        logic [DATA_W-1:0] rdata;
        logic              rbit9;
    } st_t;

    st_t cur_q, nxt_d;

    logic              run;
    logic              fall_tick;
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] fifo_head;
    logic              fifo_empty, fifo_full;
    logic              pop_ok, push_ok;
    logic              cont_q, irq_en_q;
    logic [DIV_W-1:0]  div_q;

    assign run      = cur_q.single | cur_q.cont;
    assign cont_q   = cur_q.cont;
    assign irq_en_q = cur_q.irq_en;
    assign div_q    = cur_q.div;

    srx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div       (cur_q.div),
        .sclk      (sclk_o),
        .fall_tick (fall_tick)
    );

    srx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .fall_tick (fall_tick),
        .sdata     (sdata_i),
        .nine      (cur_q.nine),
        .done      (word_done),
        .word      (word)
    );

    srx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ok),
        .push_data (word),
        .pop       (pop_ok),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    always_comb begin
        pop_ok  = data_rd && !fifo_empty;
        push_ok = word_done && !cur_q.overrun && (!fifo_full || pop_ok);
        nxt_d   = cur_q;

        if (ctl_wr) begin
            nxt_d.single = ctl_wdata[CTL_SINGLE];
            nxt_d.cont   = ctl_wdata[CTL_CONT];
            nxt_d.nine   = ctl_wdata[CTL_NINE];
            nxt_d.irq_en = ctl_wdata[CTL_IRQEN];
        end else if (word_done && !cur_q.cont) begin
            nxt_d.single = 1'b0;
        end

        if (ctl_wr && !ctl_wdata[CTL_CONT]) begin
            nxt_d.overrun = 1'b0;
        end else if (word_done && !cur_q.overrun && fifo_full && !pop_ok) begin
            nxt_d.overrun = 1'b1;
        end

        if (div_wr) nxt_d.div = div_wdata;

        if (pop_ok) begin
            nxt_d.rdata = fifo_head[DATA_W-1:0];
            nxt_d.rbit9 = fifo_head[DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rx_data   = cur_q.rdata;
    assign rx_bit9   = cur_q.rbit9;
    assign rx_ready  = !fifo_empty;
    assign overrun   = cur_q.overrun;
    assign irq       = rx_ready & cur_q.irq_en;
    assign single_on = cur_q.single;
endmodule

// File: rtl/srx_checks.sv
module srx_checks #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ctl_wr,
    input logic [srx_pkg::CTL_W-1:0] ctl_wdata,
    input logic                      data_rd,
    input logic                      sclk_o,
    input logic [DATA_W-1:0]         rx_data,
    input logic                      rx_ready,
    input logic                      overrun,
    input logic                      single_on,
    input logic                      cont_q,
    input logic [DIV_W-1:0]          div_q,
    input logic                      word_done,
    input logic                      push_ok
);
    logic             run;
    logic             prev_s;
    logic             seen;
    logic [DIV_W:0]   hold;
    logic             clr_wr;

    assign run    = single_on | cont_q;
    assign clr_wr = ctl_wr && !ctl_wdata[srx_pkg::CTL_CONT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_s <= 1'b0;
            seen   <= 1'b0;
            hold   <= '0;
        end else begin
            prev_s <= sclk_o;
            if (!run) begin
                hold <= '0;
                seen <= 1'b0;
            end else if (sclk_o != prev_s) begin
                hold <= '0;
                seen <= 1'b1;
            end else begin
                hold <= hold + 1'b1;
            end
        end
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_on && !cont_q) |=> !sclk_o);

    p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && seen && sclk_o != prev_s) |-> hold == {1'b0, div_q});

    p_single_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && single_on && !cont_q && !ctl_wr) |=> !single_on);

    p_ready_from_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(push_ok));

    p_overrun_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !push_ok);

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_wr) |=> overrun);

    p_overrun_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !overrun);

    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_ready) |=> $stable(rx_data));
endmodule

bind sync_rx_master srx_checks #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .data_rd   (data_rd),
    .sclk_o    (sclk_o),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .overrun   (overrun),
    .single_on (single_on),
    .cont_q    (cont_q),
    .div_q     (div_q),
    .word_done (word_done),
    .push_ok   (push_ok)
);

// File: tb/sync_rx_master_test.sv
`timescale 1ns/1ps
module sync_rx_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic       div_wr = 1'b0;
    logic [7:0] div_wdata = '0;
    logic       data_rd = 1'b0;
    logic       sdata_i;
    logic       sclk_o;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ready, overrun, irq, single_on;

    int total = 0;
    int bad   = 0;

    logic bitq [0:127];
    int   fill = 0;
    int   bidx = 0;

    always #5 clk = ~clk;

    sync_rx_master uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata), .data_rd(data_rd),
        .sdata_i(sdata_i), .sclk_o(sclk_o), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_ready(rx_ready), .overrun(overrun),
        .irq(irq), .single_on(single_on)
    );

    // serial source: new bit shortly after each rising shift-clock edge
    initial begin
        sdata_i = 1'b0;
        forever begin
            @(posedge sclk_o);
            #1;
            sdata_i = (bidx < 128) ? bitq[bidx] : 1'b0;
            bidx++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic int exp_half(input int d);
        return (d + 1) * 10;
    endfunction

    function automatic int exp_word(input logic [8:0] w, input bit nine);
        return nine ? int'(w) : int'(w[7:0]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stream();
        for (int i = 0; i < 128; i++) bitq[i] = 1'b0;
        fill = 0;
        bidx = 0;
    endtask

    task automatic add_word(input logic [8:0] w, input int nb);
        for (int b = 0; b < nb; b++) begin
            bitq[fill] = w[b];
            fill++;
        end
    endtask

    task automatic ctl_write(input logic [3:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic div_write(input logic [7:0] v);
        @(negedge clk); div_wr = 1'b1; div_wdata = v;
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic wait_ready(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rx_ready) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        bit          ok;
        logic [8:0]  w, w2;
        logic [8:0]  ws [0:4];
        int          d, t0, t1, t2, lowcnt;
        bit          nine;
        logic [7:0]  hold_data;
        logic        hold_b9;

        void'($urandom(32'd7731));
        clear_stream();
        repeat (3) @(negedge clk);
        // R11: reset state
        check(sclk_o == 0 && rx_ready == 0 && overrun == 0 && irq == 0 &&
              single_on == 0 && rx_data == 0 && rx_bit9 == 0, "R11 reset",
              {sclk_o, rx_ready, overrun, irq, single_on, rx_bit9}, 0);
        rst_n = 1'b1;

        // R1: idle with both requests clear
        lowcnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!sclk_o) lowcnt++;
        end
        check(lowcnt == 30, "R1 idle clock low", lowcnt, 30);

        // R3/R4/R2: one-shot 8-bit words at random dividers
        for (int n = 0; n < 6; n++) begin
            d = int'($urandom_range(0, 5));
            div_write(8'(d));
            clear_stream();
            w = 9'($urandom_range(0, 255));
            add_word(w, 8);
            ctl_write(4'b0001);
            if (n == 0) begin
                t0 = int'($time);
                @(posedge sclk_o); t1 = int'($time);
                @(posedge sclk_o); t2 = int'($time);
                check(t1 - t0 == exp_half(d) - 5, "R2 first edge delay", t1 - t0, exp_half(d) - 5);
                check(t2 - t1 == 2 * exp_half(d), "R2 period", t2 - t1, 2 * exp_half(d));
            end
            wait_ready(ok);
            check(ok, "R3 word arrives", int'(ok), 1);
            check(single_on == 0, "R4 one-shot self clear", int'(single_on), 0);
            lowcnt = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!sclk_o) lowcnt++;
            end
            check(lowcnt == 20, "R4 clock stops", lowcnt, 20);
            do_read();
            check(int'(rx_data) == exp_word(w, 0), "R3 data 8-bit", int'(rx_data), exp_word(w, 0));
            check(rx_bit9 == 0, "R3 bit9 zero in 8-bit", int'(rx_bit9), 0);
            check(rx_ready == 0, "R7 ready clears", int'(rx_ready), 0);
        end

        // R3/R7: one-shot 9-bit word with interrupt enabled
        div_write(8'd2);
        clear_stream();
        w = 9'($urandom_range(0, 511));
        add_word(w, 9);
        ctl_write(4'b1101);
        wait_ready(ok);
        check(ok && irq == 1, "R7 irq with ready", int'(irq), 1);
        do_read();
        check({rx_bit9, rx_data} == w, "R3 data 9-bit", int'({rx_bit9, rx_data}), exp_word(w, 1));
        check(irq == 0 && rx_ready == 0, "R7 irq drops", int'(irq), 0);

        // R10: read on empty queue
        hold_data = rx_data;
        hold_b9   = rx_bit9;
        do_read();
        check(rx_data == hold_data && rx_bit9 == hold_b9 && !rx_ready && !overrun,
              "R10 empty read", int'({rx_bit9, rx_data}), int'({hold_b9, hold_data}));

        // R5: both requests set -> continuous, one-shot bit stays
        div_write(8'd1);
        clear_stream();
        w  = 9'($urandom_range(0, 255));
        w2 = 9'($urandom_range(0, 255));
        add_word(w, 8); add_word(w2, 8); add_word(9'h0a5, 8);
        ctl_write(4'b0011);
        wait_ready(ok);
        do_read();
        check(int'(rx_data) == exp_word(w, 0), "R5 first word", int'(rx_data), exp_word(w, 0));
        check(single_on == 1, "R5 one-shot kept", int'(single_on), 1);
        wait_ready(ok);
        do_read();
        check(ok && int'(rx_data) == exp_word(w2, 0), "R5 second word", int'(rx_data), exp_word(w2, 0));
        check(single_on == 1, "R5 one-shot kept after two", int'(single_on), 1);
        ctl_write(4'b0000);

        // R6: random continuous two-word streams, order preserved
        for (int k = 0; k < 4; k++) begin
            d    = int'($urandom_range(0, 4));
            nine = bit'($urandom_range(0, 1));
            div_write(8'(d));
            clear_stream();
            w  = 9'($urandom_range(0, 511));
            w2 = 9'($urandom_range(0, 511));
            add_word(w, nine ? 9 : 8); add_word(w2, nine ? 9 : 8);
            ctl_write({1'b0, nine, 2'b10});
            wait_ready(ok);
            do_read();
            check(int'({rx_bit9, rx_data}) == exp_word(w, nine), "R6 order first",
                  int'({rx_bit9, rx_data}), exp_word(w, nine));
            wait_ready(ok);
            do_read();
            check(ok && int'({rx_bit9, rx_data}) == exp_word(w2, nine), "R6 order second",
                  int'({rx_bit9, rx_data}), exp_word(w2, nine));
            ctl_write(4'b0000);
        end

        // R8/R9: overrun with no reads
        div_write(8'd0);
        clear_stream();
        for (int i = 0; i < 5; i++) begin
            ws[i] = 9'($urandom_range(0, 255));
            add_word(ws[i], 8);
        end
        ctl_write(4'b0010);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (overrun) begin ok = 1'b1; break; end
        end
        check(ok, "R8 overrun raised", int'(overrun), 1);
        do_read();
        check(int'(rx_data) == exp_word(ws[0], 0), "R8 kept first", int'(rx_data), exp_word(ws[0], 0));
        do_read();
        check(int'(rx_data) == exp_word(ws[1], 0), "R8 kept second", int'(rx_data), exp_word(ws[1], 0));
        check(rx_ready == 0, "R8 third discarded", int'(rx_ready), 0);
        repeat (60) @(negedge clk);
        check(rx_ready == 0, "R8 transfers blocked", int'(rx_ready), 0);
        check(overrun == 1, "R9 overrun sticky", int'(overrun), 1);
        ctl_write(4'b0010);
        check(overrun == 1, "R9 write keeping continuous", int'(overrun), 1);
        ctl_write(4'b0000);
        check(overrun == 0, "R9 cleared by dropping continuous", int'(overrun), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule